// File: doc/BRIEF.md
# Bang-Bang Phase Tracker with Gain Doubling

This block holds phase lock once acquisition is complete. It drives the fine control word of a digitally controlled oscillator and does not touch the coarse word. On every reference cycle in which tracking is enabled, the block reads a one-bit early/late decision from an external phase detector. That decision comes from comparing the rising edges of the reference clock and the local clock. The block then moves the fine word up or down by the current step. After each such move the step doubles, so a persistent error is corrected with a geometrically growing correction.

When the decision flips polarity, the loop has crossed the lock point. On that cycle the block does not step. It puts both the fine word and the step back to the starting values that were captured when acquisition handed over. The next run of corrections therefore begins small again. A load pulse writes those starting values and also clears the polarity history.

Top module: `bbt_phase_tracker`

## Requirements
- R1: After reset the fine word output is 0 and no polarity history is held.
- R2: A cycle with `seed_load` high captures `seed_word` and `seed_step`. The fine word equals `seed_word` after that clock edge and the step becomes `seed_step`. The load clears the polarity history and takes precedence over `track_en`.
- R3: While `track_en` and `seed_load` are both low, the fine word, the step and the polarity history all hold.
- R4: With tracking enabled and no reversal, `lead_i` = 1 adds the step to the fine word and `lead_i` = 0 subtracts it.
- R5: Every enabled cycle that is not a reversal doubles the step (a left shift by one bit) for the following cycle.
- R6: The step saturates at its top bit, 2^(STEP_W-1), which is 32 by default. Once that bit is set, further doubling leaves the step unchanged.
- R7: The fine word saturates at 0 and at 2^WORD_W-1 (63 by default) instead of wrapping.
- R8: An enabled cycle whose decision differs from the last sampled decision is a reversal. On a reversal the fine word returns to the captured seed word and the step returns to the captured seed step. The word is not stepped on that cycle.
- R9: The first enabled decision after reset or after a load is never a reversal. Disabled cycles do not clear the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| track_en | input | 1 | Enables one tracking update per cycle |
| lead_i | input | 1 | Phase decision: 1 = local edge leads (raise word), 0 = lags (lower word) |
| seed_load | input | 1 | Captures seed word and step, clears history |
| seed_word | input | WORD_W | Starting fine word from acquisition |
| seed_step | input | STEP_W | Starting step from acquisition |
| fine_word_o | output | WORD_W | Fine control word to the oscillator |

## Verification
Three functions can fall in the same cycle: saturation of the word, saturation of the step, and a polarity reversal. They can also meet a load. The bench runs long one-direction streaks until the word and the step are both clamped at a rail. It then flips the decision on the following cycle and checks that the restore wins over the clamp. It also raises `seed_load` in a cycle where the decision reverses, and checks that the new seed, not the old capture, appears on the output. A behavioural model with integer state predicts the word on every clock.

// File: rtl/bbt_pkg.sv
package bbt_pkg;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } bbt_dir_e;

   function automatic logic [31:0] bbt_word_max(input int unsigned width);
      return (32'd1 << width) - 32'd1;
   endfunction

endpackage

// File: rtl/bbt_step_unit.sv
module bbt_step_unit #(
   parameter int WORD_W   = 6,
   parameter int STEP_W   = 6,
   parameter bit SATURATE = 1'b1
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [STEP_W-1:0] step_i,
   input  bbt_pkg::bbt_dir_e dir_i,
   output logic [WORD_W-1:0] word_o
);

   localparam int EXT_W = WORD_W + 1;
   localparam int PAD_W = EXT_W - STEP_W;

   logic [EXT_W-1:0] step_ext;
   logic [EXT_W-1:0] sum_up;
   logic [EXT_W-1:0] sum_dn;

   assign step_ext = {{PAD_W{1'b0}}, step_i};
   assign sum_up   = {1'b0, word_i} + step_ext;
   assign sum_dn   = {1'b0, word_i} - step_ext;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (dir_i == bbt_pkg::DIR_UP) begin
               word_o = sum_up[WORD_W] ? {WORD_W{1'b1}} : sum_up[WORD_W-1:0];
            end else begin
               word_o = sum_dn[WORD_W] ? {WORD_W{1'b0}} : sum_dn[WORD_W-1:0];
            end
         end
      end else begin : g_wrap
         assign word_o = (dir_i == bbt_pkg::DIR_UP) ? sum_up[WORD_W-1:0]
                                                    : sum_dn[WORD_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/bbt_gain_reg.sv
module bbt_gain_reg #(
   parameter int STEP_W   = 6,
   parameter bit SAT_STEP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [STEP_W-1:0] load_val_i,
   input  logic              restore_i,
   input  logic [STEP_W-1:0] restore_val_i,
   input  logic              advance_i,
   output logic [STEP_W-1:0] step_o
);

   logic [STEP_W-1:0] step_q;
   logic [STEP_W-1:0] step_dbl;

   generate
      if (SAT_STEP) begin : g_sat
         assign step_dbl = step_q[STEP_W-1] ? step_q : {step_q[STEP_W-2:0], 1'b0};
      end else begin : g_shift
         assign step_dbl = {step_q[STEP_W-2:0], 1'b0};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
      end else if (load_i) begin
         step_q <= load_val_i;
      end else if (restore_i) begin
         step_q <= restore_val_i;
      end else if (advance_i) begin
         step_q <= step_dbl;
      end
   end

   assign step_o = step_q;

endmodule

// File: rtl/bbt_reversal_det.sv
module bbt_reversal_det (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              sample_i,
   input  bbt_pkg::bbt_dir_e dir_i,
   output logic              reversal_o,
   output bbt_pkg::bbt_dir_e last_dir_o,
   output logic              hist_valid_o
);

   bbt_pkg::bbt_dir_e last_q;
   logic              valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q  <= bbt_pkg::DIR_DOWN;
         valid_q <= 1'b0;
      end else if (clear_i) begin
         valid_q <= 1'b0;
      end else if (sample_i) begin
         last_q  <= dir_i;
         valid_q <= 1'b1;
      end
   end

   assign reversal_o   = sample_i && !clear_i && valid_q && (dir_i != last_q);
   assign last_dir_o   = last_q;
   assign hist_valid_o = valid_q;

endmodule

// File: rtl/bbt_phase_tracker.sv
module bbt_phase_tracker #(
   parameter int WORD_W   = 6,
   parameter int STEP_W   = 6,
   parameter bit SAT_WORD = 1'b1,
   parameter bit SAT_STEP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              track_en,
   input  logic              lead_i,
   input  logic              seed_load,
   input  logic [WORD_W-1:0] seed_word,
   input  logic [STEP_W-1:0] seed_step,
   output logic [WORD_W-1:0] fine_word_o
);

   generate
      if (WORD_W < 2 || WORD_W > 16) begin : g_bad_word
         $error("bbt_phase_tracker: WORD_W must lie in 2..16");
      end
      if (STEP_W < 2 || STEP_W > WORD_W) begin : g_bad_step
         $error("bbt_phase_tracker: STEP_W must lie in 2..WORD_W");
      end
   endgenerate

   bbt_pkg::bbt_dir_e dir;
   bbt_pkg::bbt_dir_e last_dir;
   logic              reversal;
   logic              hist_valid;
   logic              advance;
   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] word_next;
   logic [WORD_W-1:0] cap_word_q;
   logic [STEP_W-1:0] cap_step_q;
   logic [STEP_W-1:0] step;

   assign dir     = lead_i ? bbt_pkg::DIR_UP : bbt_pkg::DIR_DOWN;
   assign advance = track_en && !seed_load && !reversal;

   bbt_reversal_det u_rev (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear_i      (seed_load),
      .sample_i     (track_en),
      .dir_i        (dir),
      .reversal_o   (reversal),
      .last_dir_o   (last_dir),
      .hist_valid_o (hist_valid)
   );

   bbt_gain_reg #(.STEP_W(STEP_W), .SAT_STEP(SAT_STEP)) u_gain (
      .clk           (clk),
      .rst_n         (rst_n),
      .load_i        (seed_load),
      .load_val_i    (seed_step),
      .restore_i     (reversal),
      .restore_val_i (cap_step_q),
      .advance_i     (advance),
      .step_o        (step)
   );

   bbt_step_unit #(.WORD_W(WORD_W), .STEP_W(STEP_W), .SATURATE(SAT_WORD)) u_step (
      .word_i (word_q),
      .step_i (step),
      .dir_i  (dir),
      .word_o (word_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_word_q <= '0;
         cap_step_q <= '0;
      end else if (seed_load) begin
         cap_word_q <= seed_word;
         cap_step_q <= seed_step;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (seed_load) begin
         word_q <= seed_word;
      end else if (reversal) begin
         word_q <= cap_word_q;
      end else if (advance) begin
         word_q <= word_next;
      end
   end

   assign fine_word_o = word_q;

endmodule

// File: rtl/bbt_phase_tracker_chk.sv
module bbt_phase_tracker_chk #(
   parameter int WORD_W = 6,
   parameter int STEP_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              track_en,
   input logic              lead_i,
   input logic              seed_load,
   input logic [WORD_W-1:0] seed_word,
   input logic [WORD_W-1:0] fine_word_o,
   input logic [STEP_W-1:0] step,
   input logic [WORD_W-1:0] cap_word_q,
   input logic [STEP_W-1:0] cap_step_q,
   input logic              hist_valid,
   input bbt_pkg::bbt_dir_e last_dir
);

   logic flip;
   assign flip = track_en && !seed_load && hist_valid && (lead_i != last_dir);

   p_load_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |=> fine_word_o == $past(seed_word));

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!track_en && !seed_load) |=> ($stable(fine_word_o) && $stable(step)));

   p_up_not_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (track_en && !seed_load && !flip && lead_i) |=> fine_word_o >= $past(fine_word_o));

   p_down_not_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (track_en && !seed_load && !flip && !lead_i) |=> fine_word_o <= $past(fine_word_o));

   p_step_top_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (track_en && !seed_load && !flip && step[STEP_W-1]) |=> step == $past(step));

   p_word_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (track_en && !seed_load && !flip && lead_i && (&fine_word_o)) |=> (&fine_word_o));

   p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flip |=> (fine_word_o == $past(cap_word_q) && step == $past(cap_step_q)));

   p_fresh_history_r9: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |=> !hist_valid);

endmodule

bind bbt_phase_tracker bbt_phase_tracker_chk #(.WORD_W(WORD_W), .STEP_W(STEP_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .track_en    (track_en),
   .lead_i      (lead_i),
   .seed_load   (seed_load),
   .seed_word   (seed_word),
   .fine_word_o (fine_word_o),
   .step        (step),
   .cap_word_q  (cap_word_q),
   .cap_step_q  (cap_step_q),
   .hist_valid  (hist_valid),
   .last_dir    (last_dir)
);

// File: tb/tb_bbt_phase_tracker.sv
module tb_bbt_phase_tracker;

   localparam int WORD_W = 6;
   localparam int STEP_W = 6;
   localparam int WMAX   = (1 << WORD_W) - 1;
   localparam int GTOP   = 1 << (STEP_W - 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              track_en = 1'b0;
   logic              lead_i = 1'b0;
   logic              seed_load = 1'b0;
   logic [WORD_W-1:0] seed_word = '0;
   logic [STEP_W-1:0] seed_step = '0;
   logic [WORD_W-1:0] fine_word_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done = 1'b0;

   int m_word = 0, m_step = 0, m_cw = 0, m_cs = 0, m_prev = 0;
   bit m_valid = 1'b0;

   always #2.5 clk = ~clk;

   bbt_phase_tracker #(.WORD_W(WORD_W), .STEP_W(STEP_W)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .track_en    (track_en),
      .lead_i      (lead_i),
      .seed_load   (seed_load),
      .seed_word   (seed_word),
      .seed_step   (seed_step),
      .fine_word_o (fine_word_o)
   );

   task automatic check(input string tag, input int exp);
      checks++;
      if (int'(fine_word_o) != exp) begin
         errors++;
         $display("FAIL %s: fine_word actual=%0d expected=%0d", tag, fine_word_o, exp);
      end
   endtask

   // Drive at a falling edge, apply model at the rising edge, compare at the next falling edge.
   task automatic cyc(input bit en, input bit ld_dir, input bit ld, input int sw, input int ss);
      string tag;
      track_en  = en;
      lead_i    = ld_dir;
      seed_load = ld;
      seed_word = WORD_W'(sw);
      seed_step = STEP_W'(ss);
      @(posedge clk);
      if (ld) begin
         m_word = sw; m_step = ss; m_cw = sw; m_cs = ss; m_valid = 1'b0;
         tag = "R2";
      end else if (!en) begin
         tag = "R3";
      end else if (m_valid && (int'(ld_dir) != m_prev)) begin
         m_word = m_cw; m_step = m_cs; m_prev = ld_dir;
         tag = "R8";
      end else begin
         tag = m_valid ? "R4" : "R9";
         if (ld_dir) m_word = m_word + m_step; else m_word = m_word - m_step;
         if (m_word > WMAX) begin m_word = WMAX; tag = "R7"; end
         if (m_word < 0)    begin m_word = 0;    tag = "R7"; end
         if (m_step >= GTOP) tag = (tag == "R7") ? "R7" : "R6";
         else m_step = m_step * 2;
         m_prev = ld_dir; m_valid = 1'b1;
      end
      @(negedge clk);
      check(tag, m_word);
   endtask

   initial begin : watchdog
      while (!done && cycles < 20000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run hung, actual=%0d expected=done", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check("R1", 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 0);
      // R2: seed load
      cyc(0, 0, 1, 32, 1);
      // R9 first decision, then R4/R5 doubling upward to R7 and R6 clamps
      for (int i = 0; i < 8; i++) cyc(1, 1, 0, 0, 0);
      // R8 reversal from clamped state
      cyc(1, 0, 0, 0, 0);
      for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0);
      // R3 idle: hold, history kept across idle
      for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0);
      cyc(1, 1, 0, 0, 0);
      // alternating decisions: restore every cycle
      cyc(1, 0, 0, 0, 0);
      for (int i = 0; i < 6; i++) cyc(1, i % 2, 0, 0, 0);
      // R2 precedence: load in a reversal cycle
      cyc(1, 1, 0, 0, 0);
      cyc(1, 0, 1, 10, 3);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 0, 0, 0, 0);
      // odd seed step, downward clamp
      cyc(0, 0, 1, 5, 5);
      for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0);
      // zero step keeps word still
      cyc(0, 0, 1, 40, 0);
      for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0);
      // upper-half seed step saturates immediately
      cyc(0, 0, 1, 20, 48);
      for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0);
      cyc(1, 0, 0, 0, 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule